// File: doc/BRIEF.md
# Compressed Processor-Status Trace Encoder

This block records how a CPU executes code as a stream of 6-bit trace entries in a 64-slot circular store. It accepts one status record per instruction, with a 4-bit status code, an optional data kind and a 32-bit data word. A pure sequential instruction (code 0x1) writes nothing at once. The block counts such instructions and writes the whole run as a single entry later. Other status codes are written as single entries.

An operand value or a branch target can follow a status. It is written as a size marker and then as one tagged entry per nibble. Two configuration inputs set the operand capture size and the branch-target width. A record can expand into several entries. These are written from an internal queue, one per clock, and the input is held off with a ready signal until the queue is empty.

A debugger reads any slot through a combinational index port. It also sees the write pointer and a flag that shows the store has wrapped.

Top module: `pst_trace_enc`

## Requirements
- R1: Entries are 6 bits wide and are written to consecutive slots of a 64-slot store starting at slot 0. `wr_ptr_o` gives the next slot to be written.
- R2: A pending run of N sequential instructions (N ≥ 1) is written as entry 0x10+N before any other entry. A sequential instruction that carries captured data is counted in the run, and the run is flushed before its marker.
- R3: When a run of pure sequential instructions reaches 15, entry 0x1F is written and the count restarts at 0.
- R4: A status code other than 0x1 is written as one entry with value 0x00+code, after any pending run.
- R5: Operand capture applies when `st_kind_i`=1. `cfg_opsz_i` 0 disables it and the data is ignored. 1 writes marker 0x08 and 2 nibbles, 2 writes marker 0x09 and 4 nibbles, and 3 writes marker 0x0B and 8 nibbles.
- R6: A branch target is given when `st_kind_i`=2, with `st_data_i` holding the instruction address. The captured value is that address shifted right by one. `cfg_tgt3_i`=0 writes marker 0x0D and 4 nibbles. `cfg_tgt3_i`=1 writes marker 0x0E and 6 nibbles. `st_kind_i`=0 or 3 carries no data.
- R7: Each data nibble is written as entry 0x20+nibble, least significant nibble first.
- R8: Exactly one entry is written per clock after a record is accepted. `st_ready_o` stays low for exactly as many cycles as the record produced entries. A valid record is ignored while `st_ready_o` is low.
- R9: The write pointer wraps from 63 to 0 and overwrites the oldest entries. `wrapped_o` sets on the first wrap and stays set until reset.
- R10: `rd_data_o` returns the entry held at slot `rd_idx_i` in the same cycle.
- R11: After reset the pointer is 0, `wrapped_o` is 0, `st_ready_o` is 1, the run count is 0 and every slot reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_opsz_i | input | 2 | Operand capture: 0 off, 1 byte, 2 halfword, 3 word |
| cfg_tgt3_i | input | 1 | Branch target width: 0 two bytes, 1 three bytes |
| st_valid_i | input | 1 | Status record valid |
| st_ready_o | output | 1 | Record accepted when high together with valid |
| st_code_i | input | 4 | Status code; 0x1 is sequential execution |
| st_kind_i | input | 2 | Data kind: 0 none, 1 operand, 2 branch target, 3 none |
| st_data_i | input | 32 | Operand value or instruction address |
| rd_idx_i | input | 6 | Read slot index |
| rd_data_o | output | 6 | Entry at the read slot |
| wr_ptr_o | output | 6 | Next slot to be written |
| wrapped_o | output | 1 | Store has wrapped at least once |

## Verification
The encoder is driven with short sequential runs ended by a branch code, and with runs longer than 15, to separate an ordinary flush from the forced 0x1F flush. Sequential records carrying operands are repeated for every capture size, including capture off, which shows that marker and nibble count follow the configuration and that disabled data leaves no trace. Branch targets in both widths check the shift, the nibble order and the 3-byte marker. A record held valid while the queue drains, and a long stream that crosses slot 63, check the stall and the overwrite against a model of the whole store.

// File: rtl/pst_trace_pkg.sv
package pst_trace_pkg;
  localparam int ENT_W  = 6;
  localparam int DATA_W = 32;
  localparam int NIB_MAX = DATA_W / 4;
  localparam int MAXQ   = NIB_MAX + 3;   // run flush + code + marker + nibbles

  typedef logic [ENT_W-1:0] ent_t;

  localparam logic [3:0] CODE_SEQ = 4'h1;
  localparam logic [3:0] RUN_MAX  = 4'd15;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_OPND = 2'd1,
    KIND_TGT  = 2'd2,
    KIND_RSVD = 2'd3
  } kind_e;
endpackage

// File: rtl/pst_entry_build.sv
module pst_entry_build
  import pst_trace_pkg::*;
#(
  parameter int CW = $clog2(MAXQ + 1)
) (
  input  logic [3:0]        run_i,
  input  logic [3:0]        code_i,
  input  logic [1:0]        kind_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        opsz_i,
  input  logic              tgt3_i,
  output ent_t              ents_o [MAXQ],
  output logic [CW-1:0]     n_o,
  output logic              plain_seq_o
);
  logic              seq, opcap, tgt, hasd;
  logic [3:0]        flush_cnt;
  logic [DATA_W-1:0] payload;
  ent_t              marker;
  int                nn;

  always_comb begin
    seq       = (code_i == CODE_SEQ);
    opcap     = (kind_i == KIND_OPND) && (opsz_i != 2'd0);
    tgt       = (kind_i == KIND_TGT);
    hasd      = opcap || tgt;
    plain_seq_o = seq && !hasd;
    flush_cnt = run_i + {3'b000, seq};
    payload   = tgt ? (data_i >> 1) : data_i;
    marker    = '0;
    nn        = 0;
    if (tgt) begin
      marker = tgt3_i ? 6'h0E : 6'h0D;
      nn     = tgt3_i ? 6 : 4;
    end else begin
      case (opsz_i)
        2'd1:    begin marker = 6'h08; nn = 2; end
        2'd2:    begin marker = 6'h09; nn = 4; end
        default: begin marker = 6'h0B; nn = 8; end
      endcase
    end

    for (int i = 0; i < MAXQ; i++) ents_o[i] = '0;
    n_o = '0;
    if (plain_seq_o) begin
      if (run_i == RUN_MAX - 4'd1) begin
        ents_o[0] = {2'b01, RUN_MAX};
        n_o       = CW'(1);
      end
    end else begin
      if (flush_cnt != 4'd0) begin
        ents_o[n_o] = {2'b01, flush_cnt};
        n_o = n_o + CW'(1);
      end
      if (!seq) begin
        ents_o[n_o] = {2'b00, code_i};
        n_o = n_o + CW'(1);
      end
      if (hasd) begin
        ents_o[n_o] = marker;
        n_o = n_o + CW'(1);
        for (int i = 0; i < NIB_MAX; i++) begin
          if (i < nn) begin
            ents_o[n_o] = {2'b10, payload[4*i +: 4]};
            n_o = n_o + CW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/pst_emit_queue.sv
module pst_emit_queue
  import pst_trace_pkg::*;
#(
  parameter int CW = $clog2(MAXQ + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  ent_t          ents_i [MAXQ],
  input  logic [CW-1:0] n_i,
  output logic          we_o,
  output ent_t          wdata_o,
  output logic          busy_o
);
  ent_t          q_q [MAXQ];
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < MAXQ; i++) q_q[i] <= '0;
    end else if (load_i) begin
      cnt_q <= n_i;
      for (int i = 0; i < MAXQ; i++) q_q[i] <= ents_i[i];
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
      for (int i = 0; i < MAXQ - 1; i++) q_q[i] <= q_q[i+1];
      q_q[MAXQ-1] <= '0;
    end
  end

  assign we_o    = (cnt_q != '0);
  assign wdata_o = q_q[0];
  assign busy_o  = (cnt_q != '0);

  AST_LOAD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> cnt_q == '0);  // R8
  AST_DRAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !load_i) |=> cnt_q == $past(cnt_q) - CW'(1));  // R8
endmodule

// File: rtl/pst_trace_store.sv
module pst_trace_store
  import pst_trace_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  ent_t          wdata_i,
  input  logic [AW-1:0] rd_idx_i,
  output ent_t          rd_data_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic          wrapped_o
);
  ent_t          mem_q [DEPTH];
  logic [AW-1:0] ptr_q;
  logic          wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      wrap_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[ptr_q] <= wdata_i;
      ptr_q        <= ptr_q + AW'(1);
      if (ptr_q == AW'(DEPTH - 1)) wrap_q <= 1'b1;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign wr_ptr_o  = ptr_q;
  assign wrapped_o = wrap_q;

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> wr_ptr_o == $past(wr_ptr_o) + AW'(1));  // R1
  AST_WRAP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_ptr_o == AW'(DEPTH - 1)) |=> wrapped_o);  // R9
  AST_WRAP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrapped_o |=> wrapped_o);  // R9
endmodule

// File: rtl/pst_trace_enc.sv
module pst_trace_enc
  import pst_trace_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(MAXQ + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cfg_opsz_i,
  input  logic              cfg_tgt3_i,
  input  logic              st_valid_i,
  output logic              st_ready_o,
  input  logic [3:0]        st_code_i,
  input  logic [1:0]        st_kind_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [AW-1:0]     rd_idx_i,
  output logic [ENT_W-1:0]  rd_data_o,
  output logic [AW-1:0]     wr_ptr_o,
  output logic              wrapped_o
);
  logic [3:0]    run_q;
  ent_t          ents [MAXQ];
  logic [CW-1:0] n_ents;
  logic          plain_seq, accept, busy, we;
  ent_t          wdata;

  assign st_ready_o = !busy;
  assign accept     = st_valid_i && st_ready_o;

  pst_entry_build #(.CW(CW)) u_build (
    .run_i(run_q), .code_i(st_code_i), .kind_i(st_kind_i), .data_i(st_data_i),
    .opsz_i(cfg_opsz_i), .tgt3_i(cfg_tgt3_i),
    .ents_o(ents), .n_o(n_ents), .plain_seq_o(plain_seq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               run_q <= '0;
    else if (accept) begin
      if (plain_seq && run_q != RUN_MAX - 4'd1) run_q <= run_q + 4'd1;
      else                                      run_q <= '0;
    end
  end

  pst_emit_queue #(.CW(CW)) u_queue (
    .clk_i, .rst_ni, .load_i(accept && n_ents != '0), .ents_i(ents), .n_i(n_ents),
    .we_o(we), .wdata_o(wdata), .busy_o(busy)
  );

  pst_trace_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .we_i(we), .wdata_i(wdata), .rd_idx_i(rd_idx_i),
    .rd_data_o(rd_data_o), .wr_ptr_o(wr_ptr_o), .wrapped_o(wrapped_o)
  );

  AST_NO_RUN_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && plain_seq && run_q == RUN_MAX - 4'd1) |=> (run_q == '0 && !st_ready_o));  // R3
  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !plain_seq) |=> run_q == '0);  // R2
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && !st_ready_o) |=> $stable(run_q));  // R8
endmodule

// File: tb/sim_pst_trace_enc.sv
module sim_pst_trace_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_opsz = 2'd0;
  logic        cfg_tgt3 = 1'b0;
  logic        st_valid = 1'b0;
  logic        st_ready;
  logic [3:0]  st_code = 4'h0;
  logic [1:0]  st_kind = 2'd0;
  logic [31:0] st_data = '0;
  logic [5:0]  rd_idx = '0;
  logic [5:0]  rd_data;
  logic [5:0]  wr_ptr;
  logic        wrapped;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [5:0] exp_mem [64];
  logic [5:0] exp_ptr;
  logic       exp_wrap;
  int         exp_run;

  always #10 clk = ~clk;  // 50 MHz

  pst_trace_enc u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_opsz_i(cfg_opsz), .cfg_tgt3_i(cfg_tgt3),
    .st_valid_i(st_valid), .st_ready_o(st_ready), .st_code_i(st_code),
    .st_kind_i(st_kind), .st_data_i(st_data), .rd_idx_i(rd_idx),
    .rd_data_o(rd_data), .wr_ptr_o(wr_ptr), .wrapped_o(wrapped)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_push(logic [5:0] v, inout int n);
    exp_mem[exp_ptr] = v;
    if (exp_ptr == 6'd63) exp_wrap = 1'b1;
    exp_ptr = exp_ptr + 6'd1;
    n++;
  endtask

  // reference model from the requirements; returns entry count
  task automatic m_instr(logic [3:0] code, logic [1:0] kind, logic [31:0] d, output int n);
    bit seq, hasd;
    int nn;
    logic [5:0] mk;
    logic [31:0] p;
    n = 0;
    seq  = (code == 4'h1);
    hasd = (kind == 2'd2) || (kind == 2'd1 && cfg_opsz != 2'd0);
    if (seq && !hasd) begin
      exp_run++;
      if (exp_run == 15) begin m_push(6'h1F, n); exp_run = 0; end
      return;
    end
    if (seq) exp_run++;
    if (exp_run > 0) m_push(6'h10 + 6'(exp_run), n);
    exp_run = 0;
    if (!seq) m_push({2'b00, code}, n);
    if (hasd) begin
      if (kind == 2'd2) begin
        p = d >> 1; mk = cfg_tgt3 ? 6'h0E : 6'h0D; nn = cfg_tgt3 ? 6 : 4;
      end else begin
        p = d;
        mk = (cfg_opsz == 2'd1) ? 6'h08 : (cfg_opsz == 2'd2) ? 6'h09 : 6'h0B;
        nn = (cfg_opsz == 2'd1) ? 2 : (cfg_opsz == 2'd2) ? 4 : 8;
      end
      m_push(mk, n);
      for (int i = 0; i < nn; i++) m_push({2'b10, p[4*i +: 4]}, n);
    end
  endtask

  // drive one record; lows = negedges with ready low after acceptance
  task automatic send(logic [3:0] code, logic [1:0] kind, logic [31:0] d,
                      output int lows, input int n_stall = 0);
    @(negedge clk);
    while (!st_ready) @(negedge clk);
    st_valid = 1'b1; st_code = code; st_kind = kind; st_data = d;
    @(negedge clk);
    st_valid = 1'b0;
    lows = 0;
    if (n_stall > 0) begin
      st_valid = 1'b1; st_code = 4'h7; st_kind = 2'd2; st_data = 32'hFFFF_FFFF;
      for (int k = 0; k < n_stall; k++) begin
        if (!st_ready) lows++;
        @(negedge clk);
      end
      st_valid = 1'b0;
    end
    while (!st_ready) begin lows++; @(negedge clk); end
  endtask

  task automatic go(string req, logic [3:0] code, logic [1:0] kind, logic [31:0] d);
    int n, lows;
    m_instr(code, kind, d, n);
    send(code, kind, d, lows);
    chk(req, lows, n);
  endtask

  task automatic check_store(string req);
    @(negedge clk);
    chk({req, " ptr"}, wr_ptr, exp_ptr);
    chk({req, " wrapped"}, wrapped, exp_wrap);
    for (int i = 0; i < 64; i++) begin
      rd_idx = 6'(i);
      #1;
      chk({req, " slot"}, rd_data, exp_mem[i]);
    end
  endtask

  task automatic t_reset();
    chk("R11 ready", st_ready, 1);
    check_store("R11 R10 reset");
  endtask

  task automatic t_short_runs();
    int n;
    for (int i = 0; i < 3; i++) begin
      go("R8 pure seq no write", 4'h1, 2'd0, 0);
      chk("R2 run held", wr_ptr, exp_ptr);
    end
    go("R2 R4 flush then code", 4'h5, 2'd0, 0);
    go("R4 code no run", 4'h7, 2'd3, 32'h1234);
    check_store("R1 R2 R4");
  endtask

  task automatic t_long_runs();
    for (int i = 0; i < 15; i++) go("R3 run 15", 4'h1, 2'd0, 0);
    chk("R3 forced flush 0x1F", exp_mem[exp_ptr - 6'd1], 6'h1F);
    for (int i = 0; i < 17; i++) go("R3 run 17", 4'h1, 2'd0, 0);
    go("R3 R4 code after", 4'h7, 2'd0, 0);
    check_store("R3");
  endtask

  task automatic t_operands();
    cfg_opsz = 2'd0;
    go("R5 capture off", 4'h1, 2'd1, 32'hDEAD_BEEF);
    chk("R5 off ignored", wr_ptr, exp_ptr);
    for (int s = 1; s < 4; s++) begin
      cfg_opsz = 2'(s);
      go("R5 R7 seq operand", 4'h1, 2'd1, 32'h8765_4321);
      go("R5 seq", 4'h1, 2'd0, 0);
      go("R5 R7 run then operand", 4'h1, 2'd1, 32'hA5C3_0F96);
    end
    go("R5 nonseq operand", 4'h5, 2'd1, 32'h0000_00E1);
    cfg_opsz = 2'd0;
    check_store("R5 R7");
  endtask

  task automatic t_targets();
    cfg_tgt3 = 1'b0;
    go("R6 R7 2-byte", 4'h5, 2'd2, 32'h0000_1074);
    chk("R6 first nibble 0x2A", exp_mem[exp_ptr - 6'd4], 6'h2A);
    go("R6 seq", 4'h1, 2'd0, 0);
    cfg_tgt3 = 1'b1;
    go("R6 R7 3-byte", 4'h5, 2'd2, 32'h00AB_CDEF);
    go("R6 seq target", 4'h1, 2'd2, 32'h0012_3456);
    cfg_tgt3 = 1'b0;
    check_store("R6 R7");
  endtask

  task automatic t_stall();
    int n, lows;
    go("R8 seq", 4'h1, 2'd0, 0);
    cfg_tgt3 = 1'b1;
    m_instr(4'hC, 2'd2, 32'h0076_5432, n);
    send(4'hC, 2'd2, 32'h0076_5432, lows, 3);
    chk("R8 stall cycles", lows, n);
    cfg_tgt3 = 1'b0;
    check_store("R8 ignored while stalled");
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 70; i++) go("R9 fill", 4'(2 + (i % 12)), 2'd0, 0);
    chk("R9 wrapped set", wrapped, 1);
    check_store("R9 R10 wrap");
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 200000; k++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) exp_mem[i] = '0;
    exp_ptr = '0; exp_wrap = 1'b0; exp_run = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_short_runs();
    t_long_runs();
    t_operands();
    t_targets();
    t_stall();
    t_wrap();
    done = 1'b1;
    finish_run();
  end
endmodule